// File: doc/BRIEF.md
# Coefficient Bank Switching Controller

This block keeps the filter coefficients that an audio processing core reads. It holds a live coefficient set and three shadow banks. Each has 23 words of 32 bits, mapped to register addresses 0x29 through 0x3F (word index = address − 0x29). A host writes through a simple port with an 8-bit address, 32-bit data and a write strobe. A control register at 0x50 decides where coefficient writes land.

Code 000 sends writes straight to the live set. Codes 001, 010 and 011 send them to shadow bank 1, 2 or 3 instead, so a host can preload coefficients for each sample-rate family. Code 100 turns on automatic switching. In that mode, a change in the sample-rate class input copies the matching bank into the live set, one word per clock. Bank 1 serves 32 kHz, bank 2 serves 48 kHz and bank 3 serves every other rate. Entering automatic mode also starts a copy.

A headphone/speaker input turns the equalization and dynamic range stages off and back on. The live coefficients are left intact, so the speaker settings come back unchanged.

Top module: `coef_bank_ctrl`

## Requirements
- R1: During and after reset, the control register reads 0, every live word is 0, `busy_o` is low and `eq_drc_en_o` is low until the first clock after reset with `hp_mode_i` low.
- R2: A write to 0x50 stores `wdata_i[2:0]`. Reading address 0x50 returns that value zero-extended, the reserved codes 101, 110 and 111 included.
- R3: With control code 000, or a reserved code 101/110/111, a write to 0x29–0x3F updates live word (address − 0x29) at the next clock edge. It can be read back on `rd_data_o` and `live_coef_o`.
- R4: With control code 001, 010 or 011, a write to 0x29–0x3F updates shadow bank 1, 2 or 3 and leaves the live set unchanged.
- R5: Writes to addresses outside 0x29–0x3F other than 0x50 change neither the live set nor the control register.
- R6: In code 100, a change of the mapped bank starts a copy into the live set. `rate_i` 0 (32 kHz) maps to bank 1, 1 (48 kHz) to bank 2, and 2 or 3 (other) to bank 3. Switching between 2 and 3 starts no copy.
- R7: Each copy moves one word per clock, from index 0 up to index 22. `busy_o` is high for exactly 23 cycles, starting the cycle after the copy is triggered.
- R8: Writing code 100 while another code is active starts a copy of the bank that matches the current `rate_i`.
- R9: In code 100, window writes go to the live set and stay there until the next copy overwrites them.
- R10: A bank change during a copy restarts the copy from index 0 with the new bank.
- R11: Leaving code 100 during a copy stops the copy. `busy_o` is low from the second clock edge after the control write. Words already copied keep the new bank's values and the rest keep their old values.
- R12: While `hp_mode_i` is high, `eq_drc_en_o` goes low one cycle later. Headphone mode never alters the live set, so `eq_drc_en_o` returns high with the same coefficients.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe, one write per cycle |
| addr_i | input | 8 | Host write address |
| wdata_i | input | 32 | Host write data |
| rd_addr_i | input | 8 | Host read address (0x50 or coefficient window) |
| rd_data_o | output | 32 | Combinational read data, 0 for unmapped addresses |
| rate_i | input | 2 | Sample-rate class: 0 = 32 kHz, 1 = 48 kHz, 2/3 = other |
| hp_mode_i | input | 1 | High selects headphone mode |
| busy_o | output | 1 | Bank copy in progress |
| eq_drc_en_o | output | 1 | Equalization and dynamic range control enable |
| live_coef_o | output | 736 | Live coefficient set, word i at bits [32*i+31:32*i] |

## Verification
The assertions assume that `rate_i` and `hp_mode_i` are synchronous to `clk_i` and change only between edges. They also assume at most one host write per cycle. The direct-write property excludes a write to the same index that a copy moves in that same cycle, because the copy wins then. The stimulus drives every input on the falling edge and holds it for at least one full cycle. It changes `rate_i` only at points that match the scenario under test. No host write collides with a copy, except in the one test that checks an automatic-mode write is overwritten by a later swap.

// File: rtl/coef_bank_pkg.sv
package coef_bank_pkg;
  localparam logic [2:0] MODE_DIRECT = 3'd0;
  localparam logic [2:0] MODE_BANK1  = 3'd1;
  localparam logic [2:0] MODE_AUTO   = 3'd4;

  typedef enum logic [1:0] {
    RATE_32K   = 2'd0,
    RATE_48K   = 2'd1,
    RATE_OTH_A = 2'd2,
    RATE_OTH_B = 2'd3
  } rate_cls_e;
endpackage

// File: rtl/coef_mode_reg.sv
module coef_mode_reg
  import coef_bank_pkg::*;
#(
  parameter int                N_BANKS   = 3,
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 32,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h50,
  localparam int               BANK_W    = $clog2(N_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [2:0]        ctrl_o,
  output logic              auto_o,
  output logic              bank_mode_o,
  output logic [BANK_W-1:0] bank_sel_o
);
  logic [2:0] ctrl_q;
  logic       ctrl_we;

  assign ctrl_we = wr_en_i && (addr_i == CTRL_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= MODE_DIRECT;
    else if (ctrl_we) ctrl_q <= wdata_i[2:0];
  end

  assign ctrl_o      = ctrl_q;
  assign auto_o      = (ctrl_q == MODE_AUTO);
  assign bank_mode_o = (ctrl_q >= MODE_BANK1) && (ctrl_q <= 3'(N_BANKS));
  assign bank_sel_o  = BANK_W'(ctrl_q - MODE_BANK1);

  AST_CTRL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we |=> ctrl_o == $past(wdata_i[2:0])); // R2
  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we |=> $stable(ctrl_o)); // R5
endmodule

// File: rtl/coef_swap_seq.sv
module coef_swap_seq
  import coef_bank_pkg::*;
#(
  parameter int  N_BANKS = 3,
  parameter int  DEPTH   = 23,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int BANK_W  = $clog2(N_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              auto_i,
  input  logic [1:0]        rate_i,
  output logic              busy_o,
  output logic              copy_en_o,
  output logic [IDX_W-1:0]  copy_idx_o,
  output logic [BANK_W-1:0] copy_bank_o
);
  logic [BANK_W-1:0] want_bank, want_q, bank_q;
  logic [IDX_W-1:0]  idx_q;
  logic              auto_q, busy_q, start;

  always_comb begin
    unique case (rate_cls_e'(rate_i))
      RATE_32K: want_bank = BANK_W'(0);
      RATE_48K: want_bank = BANK_W'(1);
      default:  want_bank = BANK_W'(N_BANKS - 1);
    endcase
  end

  // start on entry to auto mode or on a change of target bank
  assign start = auto_i && (!auto_q || (want_bank != want_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      want_q <= '0;
      auto_q <= 1'b0;
      busy_q <= 1'b0;
      idx_q  <= '0;
      bank_q <= '0;
    end else begin
      want_q <= want_bank;
      auto_q <= auto_i;
      if (!auto_i) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else if (start) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        bank_q <= want_bank;
      end else if (busy_q) begin
        if (idx_q == IDX_W'(DEPTH - 1)) begin
          busy_q <= 1'b0;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign busy_o      = busy_q;
  assign copy_en_o   = busy_q && auto_i;
  assign copy_idx_o  = idx_q;
  assign copy_bank_o = bank_q;

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> busy_o && copy_idx_o == '0); // R6
  AST_ONE_PER_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && auto_i && !start && copy_idx_o != IDX_W'(DEPTH - 1))
      |=> busy_o && copy_idx_o == $past(copy_idx_o) + 1'b1); // R7
  AST_LAST_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && auto_i && !start && copy_idx_o == IDX_W'(DEPTH - 1)) |=> !busy_o); // R7
  AST_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_i |=> !busy_o); // R11
  AST_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && auto_i && !start) |=> $stable(copy_bank_o)); // R10
endmodule

// File: rtl/coef_store.sv
module coef_store #(
  parameter int  DATA_W  = 32,
  parameter int  DEPTH   = 23,
  parameter int  N_BANKS = 3,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int BANK_W  = $clog2(N_BANKS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          host_we_i,
  input  logic [IDX_W-1:0]              host_idx_i,
  input  logic [DATA_W-1:0]             host_data_i,
  input  logic                          host_to_bank_i,
  input  logic [BANK_W-1:0]             host_bank_i,
  input  logic                          copy_en_i,
  input  logic [IDX_W-1:0]              copy_idx_i,
  input  logic [BANK_W-1:0]             copy_bank_i,
  output logic [DEPTH-1:0][DATA_W-1:0]  live_o
);
  logic [N_BANKS-1:0][DATA_W-1:0] bank_word;
  logic [DEPTH-1:0][DATA_W-1:0]   live_q;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    logic [DEPTH-1:0][DATA_W-1:0] mem_q;
    logic                         we;
    assign we = host_we_i && host_to_bank_i && (host_bank_i == BANK_W'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  mem_q <= '0;
      else if (we)  mem_q[host_idx_i] <= host_data_i;
    end
    assign bank_word[b] = mem_q[copy_idx_i];
  end

  // copy wins over a host write to the same word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
    end else begin
      if (host_we_i && !host_to_bank_i) live_q[host_idx_i] <= host_data_i;
      if (copy_en_i)                    live_q[copy_idx_i] <= bank_word[copy_bank_i];
    end
  end

  assign live_o = live_q;

  AST_BANK_WR_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && host_to_bank_i && !copy_en_i) |=> $stable(live_o)); // R4
  AST_DIRECT_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && !host_to_bank_i && !(copy_en_i && copy_idx_i == host_idx_i))
      |=> live_o[$past(host_idx_i)] == $past(host_data_i)); // R3
  AST_IDLE_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_we_i && !copy_en_i) |=> $stable(live_o)); // R12
endmodule

// File: rtl/coef_bank_ctrl.sv
module coef_bank_ctrl
  import coef_bank_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter int                ADDR_W    = 8,
  parameter int                N_BANKS   = 3,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 8'h29,
  parameter logic [ADDR_W-1:0] WIN_LAST  = 8'h3F,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h50
) (
  input  logic                                          clk_i,
  input  logic                                          rst_ni,
  input  logic                                          wr_en_i,
  input  logic [ADDR_W-1:0]                             addr_i,
  input  logic [DATA_W-1:0]                             wdata_i,
  input  logic [ADDR_W-1:0]                             rd_addr_i,
  output logic [DATA_W-1:0]                             rd_data_o,
  input  logic [1:0]                                    rate_i,
  input  logic                                          hp_mode_i,
  output logic                                          busy_o,
  output logic                                          eq_drc_en_o,
  output logic [(int'(WIN_LAST)-int'(WIN_BASE)+1)*DATA_W-1:0] live_coef_o
);
  localparam int DEPTH  = int'(WIN_LAST) - int'(WIN_BASE) + 1;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int BANK_W = $clog2(N_BANKS);

  logic [2:0]                   ctrl;
  logic                         auto_mode, bank_mode;
  logic [BANK_W-1:0]            bank_sel, copy_bank;
  logic                         copy_en;
  logic [IDX_W-1:0]             copy_idx, wr_idx, rd_idx;
  logic                         wr_in_win, rd_in_win;
  logic [DEPTH-1:0][DATA_W-1:0] live;
  logic                         eq_en_q;

  assign wr_in_win = (addr_i >= WIN_BASE) && (addr_i <= WIN_LAST);
  assign rd_in_win = (rd_addr_i >= WIN_BASE) && (rd_addr_i <= WIN_LAST);
  assign wr_idx    = IDX_W'(addr_i - WIN_BASE);
  assign rd_idx    = IDX_W'(rd_addr_i - WIN_BASE);

  coef_mode_reg #(
    .N_BANKS(N_BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
  ) u_mode (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .ctrl_o(ctrl), .auto_o(auto_mode),
    .bank_mode_o(bank_mode), .bank_sel_o(bank_sel)
  );

  coef_swap_seq #(.N_BANKS(N_BANKS), .DEPTH(DEPTH)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .auto_i(auto_mode), .rate_i(rate_i),
    .busy_o(busy_o), .copy_en_o(copy_en), .copy_idx_o(copy_idx),
    .copy_bank_o(copy_bank)
  );

  coef_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .N_BANKS(N_BANKS)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .host_we_i(wr_en_i && wr_in_win), .host_idx_i(wr_idx),
    .host_data_i(wdata_i), .host_to_bank_i(bank_mode),
    .host_bank_i(bank_sel), .copy_en_i(copy_en), .copy_idx_i(copy_idx),
    .copy_bank_i(copy_bank), .live_o(live)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == CTRL_ADDR) rd_data_o = DATA_W'(ctrl);
    else if (rd_in_win)         rd_data_o = live[rd_idx];
  end

  // equalizer/DRC enable tracks speaker mode; coefficients are never touched
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eq_en_q <= 1'b0;
    else         eq_en_q <= !hp_mode_i;
  end

  assign eq_drc_en_o = eq_en_q;
  assign live_coef_o = live;

  AST_HP_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hp_mode_i |=> !eq_drc_en_o); // R12
  AST_SPK_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hp_mode_i |=> eq_drc_en_o); // R12
  AST_BUSY_ONLY_AUTO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $past(auto_mode)); // R11
endmodule

// File: tb/tb_coef_bank_ctrl.sv
module tb_coef_bank_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 23;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [7:0]        addr = 8'h00;
  logic [31:0]       wdata = '0;
  logic [7:0]        rd_addr = 8'h00;
  logic [31:0]       rd_data;
  logic [1:0]        rate = 2'd0;
  logic              hp = 1'b0;
  logic              busy;
  logic              eq_en;
  logic [DEPTH*32-1:0] live;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [31:0] exp_live [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  coef_bank_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .rate_i(rate), .hp_mode_i(hp), .busy_o(busy), .eq_drc_en_o(eq_en),
    .live_coef_o(live)
  );

  function automatic logic [31:0] pat(int b, int i);
    return 32'hC000_003C | (32'(b + 1) << 20) | (32'(i) << 8);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_live(string req);
    int bad = 0;
    for (int i = 0; i < DEPTH; i++)
      if (live[i*32 +: 32] !== exp_live[i]) begin
        if (bad == 0) $display("FAIL %s: word %0d actual %h expected %h",
                               req, i, live[i*32 +: 32], exp_live[i]);
        bad++;
      end
    n_chk++;
    if (bad != 0) n_bad++;
  endtask

  // called at a falling edge, returns at the next falling edge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 8'h00; wdata = '0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    rd_addr = a; #1;
    chk(req, rd_data, exp);
  endtask

  task automatic wait_copy(output int cnt);
    cnt = 0;
    for (int k = 0; k < 100; k++) begin
      if (busy) cnt++;
      else if (cnt > 0) break;
      @(negedge clk);
    end
  endtask

  task automatic load_bank(int b, int from);
    for (int i = 0; i < DEPTH; i++) exp_live[i] = (i >= from) ? pat(b, i) : exp_live[i];
  endtask

  task automatic t_reset;
    chk("R1 ctrl in reset", rd_data, 32'h0);
    chk("R1 busy in reset", 32'(busy), 32'h0);
    chk("R1 eq_en in reset", 32'(eq_en), 32'h0);
    for (int i = 0; i < DEPTH; i++) exp_live[i] = '0;
    chk_live("R1 live in reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    rd_chk("R1 ctrl after reset", 8'h50, 32'h0);
    chk("R1 eq_en after reset", 32'(eq_en), 32'h1);
  endtask

  task automatic t_ctrl_readback;
    wr(8'h50, 32'hFFFF_FFF5);
    rd_chk("R2 reserved 101 readback", 8'h50, 32'h5);
    wr(8'h2C, 32'h1111_2222);  // reserved code acts as direct
    exp_live[3] = 32'h1111_2222;
    chk_live("R3 reserved code writes live");
    wr(8'h50, 32'h7);
    rd_chk("R2 reserved 111 readback", 8'h50, 32'h7);
    wr(8'h50, 32'h0);
    rd_chk("R2 direct readback", 8'h50, 32'h0);
  endtask

  task automatic t_direct;
    wr(8'h29, 32'hA5A5_0001);
    wr(8'h3F, 32'hA5A5_0017);
    exp_live[0] = 32'hA5A5_0001;
    exp_live[22] = 32'hA5A5_0017;
    chk_live("R3 direct first and last word");
    rd_chk("R3 readback last word", 8'h3F, 32'hA5A5_0017);
  endtask

  task automatic t_ignored;
    wr(8'h28, 32'hDEAD_0028);
    wr(8'h40, 32'hDEAD_0040);
    wr(8'h51, 32'hDEAD_0004);
    chk_live("R5 outside window live unchanged");
    rd_chk("R5 ctrl unchanged", 8'h50, 32'h0);
    rd_chk("R5 unmapped read zero", 8'h40, 32'h0);
  endtask

  task automatic t_bank_fill;
    for (int b = 0; b < 3; b++) begin
      wr(8'h50, 32'(b + 1));
      for (int i = 0; i < DEPTH; i++) wr(8'(8'h29 + i), pat(b, i));
    end
    chk_live("R4 shadow writes leave live");
    wr(8'h50, 32'h0);
  endtask

  task automatic t_auto_enter;
    int cnt;
    rate = 2'd0;
    @(negedge clk);
    wr(8'h50, 32'h4);
    wait_copy(cnt);
    chk("R7 busy length", 32'(cnt), 32'd23);
    load_bank(0, 0);
    chk_live("R8 entry copies bank 1 at 32k");
  endtask

  task automatic t_rate_changes;
    int cnt;
    rate = 2'd1; @(negedge clk);
    wait_copy(cnt);
    chk("R7 busy length 48k", 32'(cnt), 32'd23);
    load_bank(1, 0);
    chk_live("R6 48k selects bank 2");
    rate = 2'd2; @(negedge clk);
    wait_copy(cnt);
    load_bank(2, 0);
    chk_live("R6 other selects bank 3");
    rate = 2'd3;
    cnt = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (busy) cnt++;
    end
    chk("R6 other to other no copy", 32'(cnt), 32'd0);
  endtask

  task automatic t_auto_write;
    int cnt;
    wr(8'h30, 32'h7777_0007);
    exp_live[7] = 32'h7777_0007;
    chk_live("R9 auto write lands in live");
    rate = 2'd0; @(negedge clk);
    wait_copy(cnt);
    load_bank(0, 0);
    chk_live("R9 swap overwrites auto write");
  endtask

  task automatic t_restart;
    int cnt;
    rate = 2'd1;
    repeat (5) @(negedge clk);
    rate = 2'd2;
    wait_copy(cnt);
    chk("R10 restart busy span", 32'(cnt), 32'd24);
    load_bank(2, 0);
    chk_live("R10 restart ends with new bank");
  endtask

  task automatic t_abort;
    rate = 2'd0;
    repeat (3) @(negedge clk);
    wr(8'h50, 32'h0);
    @(negedge clk);
    chk("R11 busy drops after abort", 32'(busy), 32'h0);
    for (int i = 0; i < 3; i++) exp_live[i] = pat(0, i);
    chk_live("R11 partial copy kept");
    repeat (30) @(negedge clk);
    chk_live("R11 no copy after abort");
  endtask

  task automatic t_headphone;
    hp = 1'b1; @(negedge clk);
    chk("R12 eq off in headphone", 32'(eq_en), 32'h0);
    repeat (5) @(negedge clk);
    chk_live("R12 live intact in headphone");
    hp = 1'b0; @(negedge clk);
    chk("R12 eq back on", 32'(eq_en), 32'h1);
    chk_live("R12 coefficients restored");
  endtask

  initial begin
    rd_addr = 8'h50;
    #1;
    t_reset();
    t_ctrl_readback();
    t_direct();
    t_ignored();
    t_bank_fill();
    t_auto_enter();
    t_rate_changes();
    t_auto_write();
    t_restart();
    t_abort();
    t_headphone();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule